// File: doc/BRIEF.md
# Sticky Alarm Status Controller

This block keeps one sticky flag per fault source, including the serial-link CRC fault. A flag is set whenever its live fault input is high and stays set after the fault goes away. The flags are cleared only by a read of the status register that passes its CRC check. The host's read of the status register spans one serial frame. When that frame starts, the block returns the current flags as read data and clears them. While the frame is open, it collects any fault activity. When the frame ends, it latches the flags again from that activity and from the live faults. If the frame's CRC turns out to be bad, the flags from before the read are put back, so no information is lost.

From the flags the block drives three alarm outputs, each gated by a per-bit mask register. The first is an alarm-request bit that is latched at every frame start and carried in the outgoing frame. The second is an active-low alarm pin, which is further gated by a per-bit action-enable register. The third is an interrupt pin. In level mode the interrupt pin follows the OR of the unmasked flags, so software can unmask one flag at a time and poll each one without clearing anything. In edge mode it gives a one-cycle pulse when a new unmasked flag appears. Fault detection and the serial transport sit outside this block.

Top module: `alarm_status_ctrl`

## Requirements
- R1: After reset, all flags and the read data are 0, the masks and action enables are 0 (mask 0 = unmasked), the interrupt mode is edge, `alarm_no` is 1, and `irq_o` and `alarm_req_o` are 0.
- R2: Outside an open readback frame, a flag whose `fault_i` bit is high at a clock edge is 1 from that edge on, and stays 1 after the fault goes low.
- R3: On an accepted `rd_start_i` (no readback frame open), `rdata_o` takes the flags OR the live `fault_i` of that cycle. `status_o` is 0 from the next cycle until the frame ends.
- R4: On `rd_end_i` with `crc_ok_i`=1, the flags become the OR of `fault_i` over the cycles after the start edge up to and including the end edge. A flag that was set before the read and has no activity in that window stays 0.
- R5: On `rd_end_i` with `crc_ok_i`=0, the flags become the R4 result OR the value returned in `rdata_o` at the start.
- R6: At each `frame_start_i` edge, `alarm_req_o` takes the OR of (flags AND NOT mask) and holds that value until the next `frame_start_i`.
- R7: A flag whose mask bit is 1 has no effect on `alarm_req_o`, `alarm_no` or `irq_o`. The flag itself is unaffected.
- R8: `alarm_no` is 0 one cycle after any flag is set with mask 0 and action enable 1, and is 1 otherwise.
- R9: In level mode (`cfg_irq_lvl_i`=1 written), `irq_o` equals the OR of the unmasked flags of the previous cycle.
- R10: In edge mode, `irq_o` is 1 for one cycle, one cycle after an unmasked flag becomes 1 that was not an unmasked 1 in the cycle before.
- R11: `rd_end_i` with no open readback frame, and `rd_start_i` while a frame is open, have no effect.
- R12: `cfg_we_i` writes mask, action enable and interrupt mode together, and they take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | N_FLT | Live fault conditions, one bit per source |
| frame_start_i | input | 1 | Pulse at the start of every serial frame |
| rd_start_i | input | 1 | Pulse at the start of a status readback frame |
| rd_end_i | input | 1 | Pulse at the end of a status readback frame |
| crc_ok_i | input | 1 | CRC result of the readback frame, valid with rd_end_i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mask_i | input | N_FLT | Mask bits (1 = masked) |
| cfg_act_i | input | N_FLT | Alarm-pin action enables |
| cfg_irq_lvl_i | input | 1 | Interrupt mode: 1 level, 0 edge |
| status_o | output | N_FLT | Current sticky flags |
| rdata_o | output | N_FLT | Flags returned by the last accepted readback |
| alarm_req_o | output | 1 | Alarm-request bit for the outgoing frame |
| alarm_no | output | 1 | Alarm pin, active low |
| irq_o | output | 1 | Interrupt pin |

## Verification
On every cycle the assertions check four things. Outside a readback frame, a flag never drops. An accepted start always empties the flags. Live faults at a frame end are always latched. A failed CRC never loses the flags saved at the start. They also check that the alarm-request bit moves only at frame starts, and that a low alarm pin always traces back to an unmasked flag. Some properties are shown only by the bench's cycle-by-cycle model and its directed scenarios. These are: a flag that has gone quiet is lost across a good read, a frame end or start in the wrong state is ignored, and the exact one-cycle interrupt pulse in edge mode.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic {
    IRQ_EDGE  = 1'b0,
    IRQ_LEVEL = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/alarm_sticky_cell.sv
module alarm_sticky_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic go_i,
  input  logic fin_i,
  input  logic busy_i,
  input  logic crc_ok_i,
  output logic stat_o,
  output logic save_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= 1'b0;
      save_o <= 1'b0;
      pend_q <= 1'b0;
    end else if (go_i) begin
      save_o <= stat_o | fault_i;
      stat_o <= 1'b0;
      pend_q <= 1'b0;
    end else if (fin_i) begin
      // bad CRC restores what was reported at frame start
      stat_o <= pend_q | fault_i | (save_o & ~crc_ok_i);
    end else if (busy_i) begin
      pend_q <= pend_q | fault_i;
    end else begin
      stat_o <= stat_o | fault_i;
    end
  end
endmodule

// File: rtl/alarm_sticky_bank.sv
module alarm_sticky_bank #(
  parameter int unsigned N_FLT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_FLT-1:0] fault_i,
  input  logic             rd_start_i,
  input  logic             rd_end_i,
  input  logic             crc_ok_i,
  output logic [N_FLT-1:0] status_o,
  output logic [N_FLT-1:0] rdata_o
);
  logic busy_q;
  logic rd_go, rd_fin;

  assign rd_go  = rd_start_i & ~busy_q;
  assign rd_fin = rd_end_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (rd_go)  busy_q <= 1'b1;
    else if (rd_fin) busy_q <= 1'b0;
  end

  for (genvar i = 0; i < N_FLT; i++) begin : g_cell
    alarm_sticky_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fault_i  (fault_i[i]),
      .go_i     (rd_go),
      .fin_i    (rd_fin),
      .busy_i   (busy_q),
      .crc_ok_i (crc_ok_i),
      .stat_o   (status_o[i]),
      .save_o   (rdata_o[i])
    );
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !rd_start_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R3
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i && !busy_q) |=> (status_o == '0));

  // R4
  end_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_end_i) |=> ((status_o & $past(fault_i)) == $past(fault_i)));

  // R5
  bad_crc_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_end_i && !crc_ok_i) |=> ((status_o & $past(rdata_o)) == $past(rdata_o)));
endmodule

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import alarm_pkg::*;
#(
  parameter int unsigned N_FLT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [N_FLT-1:0] cfg_mask_i,
  input  logic [N_FLT-1:0] cfg_act_i,
  input  logic             cfg_irq_lvl_i,
  output logic [N_FLT-1:0] mask_o,
  output logic [N_FLT-1:0] act_o,
  output irq_mode_e        irq_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '0;
      act_o      <= '0;
      irq_mode_o <= IRQ_EDGE;
    end else if (cfg_we_i) begin
      mask_o     <= cfg_mask_i;
      act_o      <= cfg_act_i;
      irq_mode_o <= cfg_irq_lvl_i ? IRQ_LEVEL : IRQ_EDGE;
    end
  end
endmodule

// File: rtl/alarm_report.sv
module alarm_report
  import alarm_pkg::*;
#(
  parameter int unsigned N_FLT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_FLT-1:0] status_i,
  input  logic [N_FLT-1:0] mask_i,
  input  logic [N_FLT-1:0] act_i,
  input  irq_mode_e        irq_mode_i,
  input  logic             frame_start_i,
  output logic             alarm_req_o,
  output logic             alarm_no,
  output logic             irq_o
);
  logic [N_FLT-1:0] unm, unm_q;

  assign unm = status_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unm_q       <= '0;
      alarm_req_o <= 1'b0;
      alarm_no    <= 1'b1;
      irq_o       <= 1'b0;
    end else begin
      unm_q    <= unm;
      alarm_no <= ~|(unm & act_i);
      if (frame_start_i) alarm_req_o <= |unm;
      if (irq_mode_i == IRQ_LEVEL) irq_o <= |unm;
      else                         irq_o <= |(unm & ~unm_q);
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(alarm_req_o));

  // R7
  pin_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_no |-> $past(|(status_i & ~mask_i)));
endmodule

// File: rtl/alarm_status_ctrl.sv
module alarm_status_ctrl
  import alarm_pkg::*;
#(
  parameter int unsigned N_FLT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_FLT-1:0] fault_i,
  input  logic             frame_start_i,
  input  logic             rd_start_i,
  input  logic             rd_end_i,
  input  logic             crc_ok_i,
  input  logic             cfg_we_i,
  input  logic [N_FLT-1:0] cfg_mask_i,
  input  logic [N_FLT-1:0] cfg_act_i,
  input  logic             cfg_irq_lvl_i,
  output logic [N_FLT-1:0] status_o,
  output logic [N_FLT-1:0] rdata_o,
  output logic             alarm_req_o,
  output logic             alarm_no,
  output logic             irq_o
);
  logic [N_FLT-1:0] mask, act;
  irq_mode_e        irq_mode;

  alarm_sticky_bank #(.N_FLT(N_FLT)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fault_i    (fault_i),
    .rd_start_i (rd_start_i),
    .rd_end_i   (rd_end_i),
    .crc_ok_i   (crc_ok_i),
    .status_o   (status_o),
    .rdata_o    (rdata_o)
  );

  alarm_cfg_regs #(.N_FLT(N_FLT)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_mask_i    (cfg_mask_i),
    .cfg_act_i     (cfg_act_i),
    .cfg_irq_lvl_i (cfg_irq_lvl_i),
    .mask_o        (mask),
    .act_o         (act),
    .irq_mode_o    (irq_mode)
  );

  alarm_report #(.N_FLT(N_FLT)) u_rep (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .status_i      (status_o),
    .mask_i        (mask),
    .act_i         (act),
    .irq_mode_i    (irq_mode),
    .frame_start_i (frame_start_i),
    .alarm_req_o   (alarm_req_o),
    .alarm_no      (alarm_no),
    .irq_o         (irq_o)
  );
endmodule

// File: tb/alarm_status_ctrl_test.sv
module alarm_status_ctrl_test;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] fault = '0, cmask = '0, cact = '0;
  logic fstart = 0, rstart = 0, rend = 0, crc_ok = 0, cwe = 0, clvl = 0;
  logic [N-1:0] status, rdata;
  logic req, alarm_n, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_status_ctrl #(.N_FLT(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .frame_start_i(fstart),
    .rd_start_i(rstart), .rd_end_i(rend), .crc_ok_i(crc_ok),
    .cfg_we_i(cwe), .cfg_mask_i(cmask), .cfg_act_i(cact), .cfg_irq_lvl_i(clvl),
    .status_o(status), .rdata_o(rdata), .alarm_req_o(req),
    .alarm_no(alarm_n), .irq_o(irq)
  );

  // behavioural reference
  int m_s, m_v, m_p, m_mask, m_act, m_uq;
  bit m_busy, m_req, m_an, m_irq, m_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = 0; m_v = 0; m_p = 0; m_mask = 0; m_act = 0; m_uq = 0;
      m_busy = 0; m_req = 0; m_an = 1; m_irq = 0; m_lvl = 0;
    end else begin
      int u, f;
      f = int'(fault);
      u = m_s & ~m_mask & 'hFF;
      m_an = ((u & m_act) == 0);
      if (fstart) m_req = (u != 0);
      m_irq = m_lvl ? (u != 0) : ((u & ~m_uq) != 0);
      m_uq = u;
      if (cwe) begin m_mask = int'(cmask); m_act = int'(cact); m_lvl = clvl; end
      if (rstart && !m_busy) begin
        m_v = m_s | f; m_s = 0; m_p = 0; m_busy = 1;
      end else if (rend && m_busy) begin
        m_s = m_p | f | (crc_ok ? 0 : m_v); m_busy = 0;
      end else if (m_busy) m_p = m_p | f;
      else m_s = m_s | f;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 status vs model", int'(status), m_s);
      chk("R3 rdata vs model", int'(rdata), m_v);
      chk("R6 alarm_req vs model", int'(req), int'(m_req));
      chk("R8 alarm_no vs model", int'(alarm_n), int'(m_an));
      chk("R9 irq vs model", int'(irq), int'(m_irq));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic [N-1:0] m, logic [N-1:0] a, logic l);
    cmask = m; cact = a; clvl = l; cwe = 1; tick(1); cwe = 0;
  endtask

  task automatic pulse_fault(logic [N-1:0] f);
    fault = f; tick(1); fault = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2); rst_n = 1; tick(1);
    // R1
    chk("R1 status", int'(status), 0);
    chk("R1 alarm_no", int'(alarm_n), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 req", int'(req), 0);

    // R12
    cfg(8'h00, 8'hFF, 1'b1);
    // R2
    pulse_fault(8'h04); tick(2);
    chk("R2 sticky after fault gone", int'(status), 'h04);
    chk("R8 pin low", int'(alarm_n), 0);
    chk("R9 level irq", int'(irq), 1);
    // R6
    fstart = 1; tick(1); fstart = 0;
    chk("R6 req latched", int'(req), 1);
    tick(3);
    chk("R6 req held", int'(req), 1);

    // R3
    rstart = 1; tick(1); rstart = 0;
    chk("R3 rdata", int'(rdata), 'h04);
    chk("R3 cleared", int'(status), 0);
    pulse_fault(8'h20); tick(1);
    // R11 start while open
    rstart = 1; tick(1); rstart = 0;
    chk("R11 restart ignored", int'(rdata), 'h04);
    chk("R11 still cleared", int'(status), 0);
    // R4
    rend = 1; crc_ok = 1; tick(1); rend = 0;
    chk("R4 good crc relatch", int'(status), 'h20);
    // R11 end without open frame
    rend = 1; tick(1); rend = 0;
    chk("R11 stray end", int'(status), 'h20);

    // R5
    rstart = 1; tick(1); rstart = 0;
    pulse_fault(8'h02);
    rend = 1; crc_ok = 0; tick(1); rend = 0;
    chk("R5 bad crc restore", int'(status), 'h22);

    // R7
    cfg(8'h22, 8'hFF, 1'b1); tick(2);
    chk("R7 pin masked", int'(alarm_n), 1);
    chk("R7 irq masked", int'(irq), 0);
    chk("R7 flags kept", int'(status), 'h22);
    fstart = 1; tick(1); fstart = 0;
    chk("R7 req masked", int'(req), 0);

    // R10
    cfg(8'hBF, 8'hFF, 1'b0); tick(2);
    fault = 8'h40; tick(1); fault = '0; tick(1);
    chk("R10 edge pulse", int'(irq), 1);
    tick(1);
    chk("R10 pulse ends", int'(irq), 0);
    chk("R10 flags", int'(status), 'h62);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      fault  = ((r & 'h7) == 0) ? N'($urandom) : '0;
      fstart = (r[4:3] == 0);
      rstart = (r[9:6] == 0);
      rend   = (r[13:10] == 1);
      crc_ok = r[14];
      cwe    = (r[20:16] == 0);
      cmask  = N'($urandom);
      cact   = N'($urandom);
      clvl   = r[21];
      tick(1);
    end
    fault = '0; fstart = 0; rstart = 0; rend = 0; cwe = 0;
    tick(2);
    finish_run();
  end
endmodule